// File: doc/BRIEF.md
# Real-Time Counter with Alarm

This block is a slow time base for always-on logic. A 20-bit down-counting prescaler divides the input clock into a periodic tick, and each tick advances a free-running 32-bit counter. The counter is compared with a software-programmed alarm value, and a wrap from all ones back to zero is recorded. Three sticky event flags (tick, alarm, overflow) each drive an interrupt output through their own enable.

Software reaches the block through a single-cycle write strobe with an address and data, and a combinational read port on the same address. Counter and prescaler reload writes are accepted only while a configuration bit is set. While that bit is set the time base is frozen. Clearing the bit starts a fresh prescaler period from the reload value. With the default reload of 32767, a 32.768 kHz input clock gives one tick per second.

Top module: `rtc_timebase`

## Requirements
- R1: After reset the counter reads 0, the reload and divider registers read 32767, the alarm reads 0xFFFFFFFF, the control and status registers read 0, and all interrupt outputs are low.
- R2: Outside configuration the divider decreases by one per clock. While it is 0, `tick_o` is high for that cycle and the divider reloads on the next edge, so ticks come every reload+1 clocks. The divider is readable at address 5.
- R3: The counter (address 3) increases by exactly one on the clock edge that ends each tick cycle, and is otherwise unchanged.
- R4: A write to the counter (address 3) or the reload (address 2) takes effect only while control bit 0 (configuration enable) is 1. Otherwise it leaves the register unchanged.
- R5: While configuration is enabled the divider reads the reload value, no tick occurs and the counter holds. After the edge that clears the bit, the divider reads the reload value and then counts down.
- R6: Status bit 1 (alarm) becomes 1 on the edge where a tick makes the counter equal to the alarm register (address 4), and not earlier.
- R7: A tick with the counter at 0xFFFFFFFF wraps it to 0 and sets status bit 2 (overflow) on that edge.
- R8: Status flags (bit 0 tick, bit 1 alarm, bit 2 overflow, address 1) stay set until software writes 1 to the bit. Writing 0 leaves the flag unchanged.
- R9: `tick_irq_o`, `alarm_irq_o` and `ovf_irq_o` are each high when their flag is set and the matching enable is set: control bit 1, bit 2 and bit 3 respectively (address 0).
- R10: The alarm register can be written and read back whatever the state of the configuration bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time base input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| addr_i | input | 3 | Register address: 0 ctrl, 1 status, 2 reload, 3 counter, 4 alarm, 5 divider |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| tick_o | output | 1 | One-cycle tick pulse |
| tick_irq_o | output | 1 | Tick interrupt |
| alarm_irq_o | output | 1 | Alarm interrupt |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong divider value shows up within one clock, because the divider is readable and is compared on every cycle after configuration is left. A wrong tick period shows up within one period as a misplaced `tick_o` pulse and, on the following edge, as a counter step that comes early or late. The alarm and overflow comparisons are checked one tick before their target and on the exact edge where they fire, so an off-by-one compare is caught in a single tick. Ignored writes are read back straight after the write, before any tick can hide the result.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_STATUS = 3'd1,
    ADDR_RELOAD = 3'd2,
    ADDR_COUNT  = 3'd3,
    ADDR_ALARM  = 3'd4,
    ADDR_DIV    = 3'd5
  } rtc_addr_e;

  localparam int unsigned NUM_EVT = 3;
  localparam int unsigned EVT_TICK  = 0;
  localparam int unsigned EVT_ALARM = 1;
  localparam int unsigned EVT_OVF   = 2;
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int unsigned PRESC_W = 20,
  parameter logic [PRESC_W-1:0] PRESC_RESET = PRESC_W'(32767)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               ld_i,
  input  logic [PRESC_W-1:0] ld_val_i,
  output logic [PRESC_W-1:0] reload_o,
  output logic [PRESC_W-1:0] div_o,
  output logic               tick_o
);
  logic [PRESC_W-1:0] reload_q, div_q;

  assign tick_o   = !hold_i && (div_q == '0);
  assign reload_o = reload_q;
  assign div_o    = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= PRESC_RESET;
      div_q    <= PRESC_RESET;
    end else begin
      if (ld_i) reload_q <= ld_val_i;
      if (hold_i)           div_q <= ld_i ? ld_val_i : reload_q;
      else if (div_q == '0) div_q <= reload_q;
      else                  div_q <= div_q - PRESC_W'(1);
    end
  end

  a_r2_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && div_q != '0) |=> (div_q == $past(div_q) - PRESC_W'(1)));
  a_r2_reload_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (div_q == $past(reload_q)));
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> (div_q == reload_q));
endmodule

// File: rtl/rtc_counter.sv
`timescale 1ns/1ps
module rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             alarm_wr_i,
  input  logic [CNT_W-1:0] alarm_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             hit_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, alarm_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign hit_o   = tick_i && (cnt_nxt == alarm_q);
  assign wrap_o  = tick_i && (cnt_q == '1);
  assign cnt_o   = cnt_q;
  assign alarm_o = alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      alarm_q <= '1;
    end else begin
      if (wr_i)        cnt_q <= wr_val_i;
      else if (tick_i) cnt_q <= cnt_nxt;
      if (alarm_wr_i)  alarm_q <= alarm_val_i;
    end
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !wr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_flags.sv
`timescale 1ns/1ps
module rtc_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;   // set wins over clear
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[i]) |=> q);
  end
endmodule

// File: rtl/rtc_timebase.sv
`timescale 1ns/1ps
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_W = 20,
  parameter int unsigned CNT_W   = 32,
  parameter logic [PRESC_W-1:0] PRESC_RESET = PRESC_W'(32767)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             tick_o,
  output logic             tick_irq_o,
  output logic             alarm_irq_o,
  output logic             ovf_irq_o
);
  logic               cfg_q;
  logic [NUM_EVT-1:0] ie_q, evt_set, evt_clr, flags;
  logic               tick, hit, wrap;
  logic [PRESC_W-1:0] reload, div;
  logic [CNT_W-1:0]   cnt, alarm;
  logic               wr_ctrl, wr_stat, wr_rel, wr_cnt, wr_alm;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_stat = wr_en_i && (addr_i == ADDR_STATUS);
  assign wr_rel  = wr_en_i && (addr_i == ADDR_RELOAD) && cfg_q;
  assign wr_cnt  = wr_en_i && (addr_i == ADDR_COUNT)  && cfg_q;
  assign wr_alm  = wr_en_i && (addr_i == ADDR_ALARM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0;
      ie_q  <= '0;
    end else if (wr_ctrl) begin
      cfg_q <= wdata_i[0];
      ie_q  <= wdata_i[NUM_EVT:1];
    end
  end

  rtc_prescaler #(.PRESC_W(PRESC_W), .PRESC_RESET(PRESC_RESET)) u_presc (
    .clk_i, .rst_ni,
    .hold_i   (cfg_q),
    .ld_i     (wr_rel),
    .ld_val_i (wdata_i[PRESC_W-1:0]),
    .reload_o (reload),
    .div_o    (div),
    .tick_o   (tick)
  );

  rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i      (tick),
    .wr_i        (wr_cnt),
    .wr_val_i    (wdata_i),
    .alarm_wr_i  (wr_alm),
    .alarm_val_i (wdata_i),
    .cnt_o       (cnt),
    .alarm_o     (alarm),
    .hit_o       (hit),
    .wrap_o      (wrap)
  );

  always_comb begin
    evt_set            = '0;
    evt_set[EVT_TICK]  = tick;
    evt_set[EVT_ALARM] = hit;
    evt_set[EVT_OVF]   = wrap;
    evt_clr            = wr_stat ? wdata_i[NUM_EVT-1:0] : '0;
  end

  rtc_flags #(.N(NUM_EVT)) u_flags (
    .clk_i, .rst_ni,
    .set_i (evt_set),
    .clr_i (evt_clr),
    .q_o   (flags)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL:   rdata_o = CNT_W'({ie_q, cfg_q});
      ADDR_STATUS: rdata_o = CNT_W'(flags);
      ADDR_RELOAD: rdata_o = CNT_W'(reload);
      ADDR_COUNT:  rdata_o = cnt;
      ADDR_ALARM:  rdata_o = alarm;
      ADDR_DIV:    rdata_o = CNT_W'(div);
      default:     rdata_o = '0;
    endcase
  end

  assign tick_o      = tick;
  assign tick_irq_o  = flags[EVT_TICK]  & ie_q[EVT_TICK];
  assign alarm_irq_o = flags[EVT_ALARM] & ie_q[EVT_ALARM];
  assign ovf_irq_o   = flags[EVT_OVF]   & ie_q[EVT_OVF];

  a_r4_count_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q && !wr_cnt) |=> $stable(cnt));
  a_r6_alarm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flags[EVT_ALARM]);
endmodule

// File: tb/rtc_timebase_test.sv
`timescale 1ns/1ps
module rtc_timebase_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_o, tick_irq_o, alarm_irq_o, ovf_irq_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_timebase uut (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .tick_o, .tick_irq_o, .alarm_irq_o, .ovf_irq_o
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #0.1;
    d = rdata_o;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] start;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, v); chk("R1 count", v, 32'd0);
    rd(3'd2, v); chk("R1 reload", v, 32'd32767);
    rd(3'd5, v); chk("R1 divider", v, 32'd32766);
    rd(3'd4, v); chk("R1 alarm", v, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R1 ctrl", v, 32'd0);
    rd(3'd1, v); chk("R1 status", v, 32'd0);
    chk("R1 irqs", {29'd0, tick_irq_o, alarm_irq_o, ovf_irq_o}, 32'd0);

    // R10 alarm writable outside configuration
    wr(3'd4, 32'd5000);
    rd(3'd4, v); chk("R10 alarm readback", v, 32'd5000);

    // R2/R3/R5 sweep over reload values, checked every cycle
    for (int r = 0; r <= 5; r++) begin
      start = 32'(16 * r + 3);
      wr(3'd0, 32'd1);
      wr(3'd2, 32'(r));
      wr(3'd3, start);
      wr(3'd0, 32'd0);
      for (int n = 0; n <= 4 * (r + 1); n++) begin
        if (n > 0) @(negedge clk);
        rd(3'd5, v);
        chk(n == 0 ? "R5 restart divider" : "R2 divider", v, 32'(r - (n % (r + 1))));
        chk("R2 tick pulse", {31'd0, tick_o}, {31'd0, (n % (r + 1)) == r});
        rd(3'd3, v);
        chk("R3 count", v, start + 32'(n / (r + 1)));
      end
    end

    // R4 writes ignored outside configuration
    wr(3'd0, 32'd1);
    wr(3'd2, 32'd1000);
    wr(3'd3, 32'd7);
    wr(3'd0, 32'd0);
    wr(3'd3, 32'd99);
    rd(3'd3, v); chk("R4 count write ignored", v, 32'd7);
    wr(3'd2, 32'd5);
    rd(3'd2, v); chk("R4 reload write ignored", v, 32'd1000);

    // R5 frozen while configuring
    wr(3'd0, 32'd1);
    wr(3'd2, 32'd0);
    wait_n(10);
    rd(3'd3, v); chk("R5 count frozen", v, 32'd7);
    rd(3'd5, v); chk("R5 divider at reload", v, 32'd0);
    chk("R5 no tick", {31'd0, tick_o}, 32'd0);

    // R8 clear while frozen, R6 alarm, R9 gating
    wr(3'd1, 32'd7);
    rd(3'd1, v); chk("R8 write-1 clears", v, 32'd0);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd5);
    wr(3'd0, 32'd4);            // leave config, alarm irq enabled
    wait_n(6);
    rd(3'd3, v); chk("R6 count before alarm", v, 32'd4);
    rd(3'd1, v); chk("R6 no early alarm", v & 32'd2, 32'd0);
    chk("R9 alarm irq low", {31'd0, alarm_irq_o}, 32'd0);
    wait_n(3);
    rd(3'd3, v); chk("R6 count at alarm", v, 32'd5);
    rd(3'd1, v); chk("R6 alarm flag", v & 32'd2, 32'd2);
    chk("R9 alarm irq high", {31'd0, alarm_irq_o}, 32'd1);
    chk("R9 tick irq masked", {31'd0, tick_irq_o}, 32'd0);
    rd(3'd1, v); chk("R9 tick flag set", v & 32'd1, 32'd1);
    wait_n(6);
    rd(3'd1, v); chk("R8 alarm sticky", v & 32'd2, 32'd2);
    wr(3'd1, 32'd0);
    rd(3'd1, v); chk("R8 write-0 keeps", v & 32'd2, 32'd2);
    wr(3'd1, 32'd2);
    rd(3'd1, v); chk("R8 alarm cleared", v & 32'd2, 32'd0);
    chk("R9 alarm irq dropped", {31'd0, alarm_irq_o}, 32'd0);

    // R7 overflow
    wr(3'd0, 32'd1);
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd1);
    wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd0, 32'd8 | 32'd2);    // leave config, ovf and tick irq enabled
    wait_n(2);
    rd(3'd3, v); chk("R7 count at max", v, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R7 no early overflow", v & 32'd4, 32'd0);
    chk("R9 tick irq enabled", {31'd0, tick_irq_o}, 32'd1);
    wait_n(2);
    rd(3'd3, v); chk("R7 wrapped", v, 32'd0);
    rd(3'd1, v); chk("R7 overflow flag", v & 32'd4, 32'd4);
    chk("R9 ovf irq", {31'd0, ovf_irq_o}, 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule